// File: doc/BRIEF.md
# Nonvolatile Page-Load Write Sequencer

This block is the device-side control for a byte-wide nonvolatile memory model. It watches the asynchronous host strobes (chip select, output enable, write strobe), an address bus and a data bus. All of these are brought onto a system clock through a synchroniser chain. Valid write strobes are gathered into a page buffer. The page is closed when no further strobe begins within a load window. A self-timed programming phase then copies only the loaded byte positions into the storage array. During that phase the block reports busy, ignores further writes, and answers reads with a polling status byte instead of array contents.

The address is split into an in-page offset (the low `PAGE_W` bits) and a page number (the remaining upper bits). Every byte after the first in one session must carry the same page number. All timing values are counts of the system clock: the minimum strobe width, the load window and the programming time. The storage array covers the low `ARR_W` address bits. A host finds out that programming has finished by polling the status bits or the busy output.

Top module: `pgwr_seq`

## Requirements
- R1: After reset `busy` is low, `dq_oe` is low, and every array location reads as all ones (0xFF for 8-bit data).
- R2: A write strobe is recognised only while chip select and write strobe are both low and output enable is high. If output enable is low during such a strobe, nothing is written and no programming phase starts.
- R3: The address is taken on the synchronised cycle in which the write condition becomes true, which is the later of the two falling strobes. The data is the value present on the last synchronised cycle before the condition ends, which is the earlier of the two rising strobes.
- R4: One to 2^PAGE_W bytes loaded in one session are committed together after the session closes. A byte loaded twice keeps its last value.
- R5: Byte positions of the page that were not loaded in the session keep their earlier contents.
- R6: In a session, a load whose page number (address bits ADDR_W-1 down to PAGE_W) differs from that of the first load is ignored. It writes nothing and does not extend the window.
- R7: A strobe with fewer than MIN_PULSE synchronised active cycles is ignored. A strobe with exactly MIN_PULSE cycles is accepted.
- R8: The session stays open as long as each new strobe begins within LOAD_WIN cycles of the start of the previous accepted one, with no limit on total length. Once a strobe arrives later than that, programming has already begun.
- R9: `busy` is high for exactly PROG_CYC cycles per session. Write strobes that arrive while busy are ignored.
- R10: A read while busy returns on bit DATA_W-1 the complement of the same bit of the last byte loaded.
- R11: While busy, bit DATA_W-2 of the read data starts at 0 for the first read of the phase and inverts after each completed read. The remaining low bits read as 0. After the phase, reads return array data.
- R12: `dq_oe` is high only while chip select and output enable are both low (after synchronisation). `dq_out` is 0 whenever `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Byte address; upper bits are the page number |
| dq_in | input | DATA_W | Write data from the host |
| dq_out | output | DATA_W | Read data or polling status |
| dq_oe | output | 1 | Drive enable for the data bus |
| busy | output | 1 | High during the programming phase |

## Verification
The gather-and-commit function is driven with full pages in every page of a small array, with sparse and repeated loads, and with one long session whose loads are spaced just inside the window. Together these separate commit-all from commit-masked behaviour and last-write-wins from first-write-wins. A second load placed just beyond the window, a page-number mismatch that differs only in bits above the array, and strobes one cycle shorter than and equal to the minimum width each show whether a load was accepted or dropped. An address and data change in the middle of a strobe shows which edge captures each. Repeated reads during programming check the complement and alternation of the two status bits against values the bench predicts.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pg_state_t;
endpackage

// File: rtl/pgwr_sync.sv
module pgwr_sync #(
   parameter int            W      = 1,
   parameter int            STAGES = 2,
   parameter logic [W-1:0]  RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= RST;
      else        st[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[i] <= RST;
         else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/pgwr_strobe.sv
module pgwr_strobe #(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int LEN_W     = 8,
   parameter int MIN_PULSE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             oe_n,
   input  logic             we_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    din,
   output logic             load_vld,
   output logic [AW-1:0]    load_addr,
   output logic [DW-1:0]    load_data,
   output logic [LEN_W-1:0] load_len,
   output logic             wr_pend,
   output logic             rd_act,
   output logic             rd_end
);
   localparam logic [LEN_W-1:0] MINP = LEN_W'(MIN_PULSE);
   localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);

   logic             wa, wa_q, rd_q;
   logic [LEN_W-1:0] len_q;

   assign wa     = !ce_n && !we_n && oe_n;
   assign rd_act = !ce_n && !oe_n;
   assign rd_end = rd_q && !rd_act;
   assign wr_pend = wa || wa_q;
   assign load_len = len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wa_q      <= 1'b0;
         rd_q      <= 1'b0;
         len_q     <= '0;
         load_vld  <= 1'b0;
         load_addr <= '0;
         load_data <= '0;
      end else begin
         wa_q     <= wa;
         rd_q     <= rd_act;
         load_vld <= !wa && wa_q && (len_q >= MINP);
         if (wa && !wa_q) begin
            load_addr <= addr;
            len_q     <= ONE;
         end else if (wa && len_q != '1) begin
            len_q <= len_q + ONE;
         end
         if (wa) load_data <= din;
      end
   end
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf #(
   parameter int PAGE_W = 7,
   parameter int DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld,
   input  logic [PAGE_W-1:0] ld_off,
   input  logic [DW-1:0]     ld_data,
   input  logic [PAGE_W-1:0] rd_off,
   output logic              rd_hit,
   output logic [DW-1:0]     rd_data
);
   localparam int NB = 1 << PAGE_W;

   logic [DW-1:0] bytes_q [NB];
   logic [NB-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else begin
         if (clr) mask_q <= '0;
         if (ld)  mask_q[ld_off] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ld) bytes_q[ld_off] <= ld_data;
   end

   assign rd_hit  = mask_q[rd_off];
   assign rd_data = bytes_q[rd_off];
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
   import pgwr_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int PAGE_W      = 7,
   parameter int ARR_W       = 10,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_PULSE   = 2,
   parameter int LOAD_WIN    = 5000,
   parameter int PROG_CYC    = 500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              busy
);
   localparam int NB     = 1 << PAGE_W;
   localparam int PG_W   = ADDR_W - PAGE_W;
   localparam int WIN_W  = $clog2(LOAD_WIN + 1);
   localparam int PROG_W = $clog2(PROG_CYC + 1);
   localparam int BUS_W  = ADDR_W + DATA_W;
   localparam logic [WIN_W-1:0]  WIN_C     = WIN_W'(LOAD_WIN);
   localparam logic [PROG_W-1:0] PROG_LAST = PROG_W'(PROG_CYC - 1);
   localparam logic [PROG_W-1:0] NB_C      = PROG_W'(NB);

   if (ARR_W <= PAGE_W || ARR_W > ADDR_W) begin : g_bad_arr
      $error("ARR_W must exceed PAGE_W and not exceed ADDR_W");
   end
   if (DATA_W < 3 || SYNC_STAGES < 1 || MIN_PULSE < 1) begin : g_bad_basic
      $error("DATA_W >= 3, SYNC_STAGES >= 1 and MIN_PULSE >= 1 are required");
   end
   if (PROG_CYC < NB || LOAD_WIN < MIN_PULSE) begin : g_bad_time
      $error("PROG_CYC must cover one page copy and LOAD_WIN must cover MIN_PULSE");
   end

   logic [2:0]        ctl_s;
   logic [BUS_W-1:0]  bus_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] din_s;

   pgwr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b111)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d({ce_n, oe_n, we_n}), .q(ctl_s));
   pgwr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST('0)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({addr, dq_in}), .q(bus_s));
   assign {addr_s, din_s} = bus_s;

   logic              load_vld, wr_pend, rd_act, rd_end;
   logic [ADDR_W-1:0] load_addr;
   logic [DATA_W-1:0] load_data;
   logic [WIN_W-1:0]  load_len;

   pgwr_strobe #(.AW(ADDR_W), .DW(DATA_W), .LEN_W(WIN_W), .MIN_PULSE(MIN_PULSE)) u_strobe (
      .clk(clk), .rst_n(rst_n),
      .ce_n(ctl_s[2]), .oe_n(ctl_s[1]), .we_n(ctl_s[0]),
      .addr(addr_s), .din(din_s),
      .load_vld(load_vld), .load_addr(load_addr), .load_data(load_data),
      .load_len(load_len), .wr_pend(wr_pend), .rd_act(rd_act), .rd_end(rd_end));

   pg_state_t          state;
   logic [PG_W-1:0]    page_q;
   logic [WIN_W-1:0]   win_cnt;
   logic [PROG_W-1:0]  prog_cnt;
   logic [DATA_W-1:0]  last_q;
   logic               tog;
   logic               page_hit, accept, buf_hit;
   logic [DATA_W-1:0]  buf_data;
   logic [DATA_W-1:0]  mem [1 << ARR_W];

   assign page_hit = load_addr[ADDR_W-1:PAGE_W] == page_q;
   assign accept   = load_vld && (state == ST_IDLE || (state == ST_LOAD && page_hit));

   pgwr_pagebuf #(.PAGE_W(PAGE_W), .DW(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .clr(load_vld && state == ST_IDLE), .ld(accept),
      .ld_off(load_addr[PAGE_W-1:0]), .ld_data(load_data),
      .rd_off(prog_cnt[PAGE_W-1:0]), .rd_hit(buf_hit), .rd_data(buf_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         page_q   <= '0;
         win_cnt  <= '0;
         prog_cnt <= '0;
         last_q   <= '0;
         tog      <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (accept) begin
               page_q  <= load_addr[ADDR_W-1:PAGE_W];
               win_cnt <= load_len;
               last_q  <= load_data;
               state   <= ST_LOAD;
            end
            ST_LOAD: if (accept) begin
               win_cnt <= load_len;
               last_q  <= load_data;
            end else if (!wr_pend && win_cnt >= WIN_C) begin
               state    <= ST_PROG;
               prog_cnt <= '0;
               tog      <= 1'b0;
            end else if (win_cnt < WIN_C) begin
               win_cnt <= win_cnt + WIN_W'(1);
            end
            ST_PROG: begin
               if (rd_end) tog <= !tog;
               if (prog_cnt == PROG_LAST) state <= ST_IDLE;
               else prog_cnt <= prog_cnt + PROG_W'(1);
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < (1 << ARR_W); i++) mem[i] <= '1;
      end else if (state == ST_PROG && prog_cnt < NB_C && buf_hit) begin
         mem[{page_q[ARR_W-PAGE_W-1:0], prog_cnt[PAGE_W-1:0]}] <= buf_data;
      end
   end

   assign busy  = state == ST_PROG;
   assign dq_oe = rd_act;

   always_comb begin
      dq_out = '0;
      if (rd_act) begin
         if (busy) dq_out = {!last_q[DATA_W-1], tog, {(DATA_W-2){1'b0}}};
         else      dq_out = mem[addr_s[ARR_W-1:0]];
      end
   end
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk #(
   parameter int S    = 2,
   parameter int PG_W = 9,
   parameter int DW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ce_n,
   input logic            oe_n,
   input logic            dq_oe,
   input logic [DW-1:0]   dq_out,
   input logic            busy,
   input logic            tog,
   input logic [PG_W-1:0] pg_q
);
   // R12: a high chip select seen S cycles back keeps the bus undriven
   a_r12_ce_high_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce_n, S) |-> !dq_oe);
   // R12: a high output enable seen S cycles back keeps the bus undriven
   a_r12_oe_high_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $past(oe_n, S) |-> !dq_oe);
   // R12: undriven bus carries zero
   a_r12_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe |-> dq_out == '0);
   // R9: programming lasts more than one cycle
   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy);
   // R9: the open page cannot change while programming
   a_r9_page_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(pg_q));
   // R11: each completed read during programming inverts the toggle bit
   a_r11_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $fell(dq_oe)) |=> (tog != $past(tog)));
endmodule

bind pgwr_seq pgwr_seq_chk #(.S(SYNC_STAGES), .PG_W(ADDR_W - PAGE_W), .DW(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dq_oe(dq_oe),
   .dq_out(dq_out), .busy(busy), .tog(tog), .pg_q(page_q));

// File: tb/sim_pgwr_seq.sv
module sim_pgwr_seq;
   localparam int CLK_P    = 10;
   localparam int S        = 2;
   localparam int PW       = 3;
   localparam int AW_ARR   = 6;
   localparam int NBYTE    = 1 << PW;
   localparam int NLOC     = 1 << AW_ARR;
   localparam int MINP     = 3;
   localparam int WIN      = 30;
   localparam int PROG     = 40;
   localparam int SETTLE   = WIN + PROG + 20;

   logic clk = 1'b0;
   logic rst_n, ce_n, oe_n, we_n;
   logic [15:0] addr;
   logic [7:0]  din;
   logic [7:0]  dq_out;
   logic        dq_oe, busy;
   logic [7:0]  model [NLOC];
   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = !clk;

   pgwr_seq #(.ADDR_W(16), .DATA_W(8), .PAGE_W(PW), .ARR_W(AW_ARR), .SYNC_STAGES(S),
              .MIN_PULSE(MINP), .LOAD_WIN(WIN), .PROG_CYC(PROG)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy));

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic [15:0] a, input logic [7:0] d, input int w);
      @(negedge clk);
      addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
      idle(w);
      we_n = 1'b1; ce_n = 1'b1;
      idle(3);
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic en);
      @(negedge clk);
      addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
      idle(S + 3);
      d = dq_out; en = dq_oe;
      ce_n = 1'b1; oe_n = 1'b1;
      idle(S + 3);
   endtask

   task automatic watch_busy(input int n, output bit seen);
      seen = 1'b0;
      repeat (n) begin
         @(negedge clk);
         if (busy) seen = 1'b1;
      end
   endtask

   task automatic wait_rise(output bit ok);
      ok = 1'b0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (busy) begin ok = 1'b1; break; end
      end
   endtask

   task automatic check_loc(input logic [15:0] a, input string req);
      logic [7:0] d;
      logic en;
      bus_read(a, d, en);
      check(en == 1'b1, req, 16'(en), 16'd1);
      check(d == model[a[AW_ARR-1:0]], req, 16'(d), 16'(model[a[AW_ARR-1:0]]));
   endtask

   initial begin
      #(CLK_P * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic en;
      bit seen, ok;
      int blen;
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0; rst_n = 1'b0;
      for (int i = 0; i < NLOC; i++) model[i] = 8'hFF;
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(busy == 1'b0, "R1 busy", 16'(busy), 16'd0);
      check(dq_oe == 1'b0, "R1 dq_oe", 16'(dq_oe), 16'd0);
      check_loc(16'h0005, "R1 erased");

      // R12: bus not driven with ce high or oe high
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b0; idle(S + 3);
      check(dq_oe == 1'b0 && dq_out == 8'h00, "R12 ce high", {7'd0, dq_oe, dq_out}, 16'h0);
      ce_n = 1'b0; oe_n = 1'b1; idle(S + 3);
      check(dq_oe == 1'b0 && dq_out == 8'h00, "R12 oe high", {7'd0, dq_oe, dq_out}, 16'h0);
      ce_n = 1'b1; idle(S + 3);

      // R4: full page in every page, then read the whole array
      for (int p = 0; p < NLOC / NBYTE; p++) begin
         for (int o = 0; o < NBYTE; o++) begin
            logic [7:0] v;
            v = 8'(p * 29 + o * 11 + 5);
            load(16'(p * NBYTE + o), v, 4);
            model[p * NBYTE + o] = v;
         end
         idle(SETTLE);
      end
      for (int a = 0; a < NLOC; a++) check_loc(16'(a), "R4 full page");

      // R5: sparse load into page 2 leaves the other bytes
      load(16'h0011, 8'hA1, 4); model[8'h11] = 8'hA1;
      load(16'h0016, 8'hB6, 4); model[8'h16] = 8'hB6;
      idle(SETTLE);
      for (int a = 16; a < 24; a++) check_loc(16'(a), "R5 sparse");

      // R6: page mismatch (bit 10 only, same array index) and another page
      load(16'h0018, 8'h41, 4); model[8'h18] = 8'h41;
      load(16'h0418, 8'h99, 4);
      load(16'h0020, 8'h5E, 4);
      idle(SETTLE);
      check_loc(16'h0018, "R6 mismatch high bits");
      check_loc(16'h0020, "R6 mismatch other page");

      // R7: pulse one cycle short of the minimum is dropped
      load(16'h0021, 8'h77, MINP - 1);
      watch_busy(SETTLE, seen);
      check(!seen, "R7 short pulse busy", 16'(seen), 16'd0);
      check_loc(16'h0021, "R7 short pulse data");
      // R7: exactly the minimum is accepted
      load(16'h0021, 8'h78, MINP); model[8'h21] = 8'h78;
      idle(SETTLE);
      check_loc(16'h0021, "R7 minimum pulse");

      // R2: strobe with output enable low writes nothing
      @(negedge clk);
      addr = 16'h0022; din = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
      idle(6);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      watch_busy(SETTLE, seen);
      check(!seen, "R2 oe low busy", 16'(seen), 16'd0);
      check_loc(16'h0022, "R2 oe low data");

      // R3: address from strobe start, data from strobe end
      @(negedge clk);
      addr = 16'h002A; din = 8'h10; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
      idle(2);
      addr = 16'h002B; din = 8'hE7;
      idle(2);
      we_n = 1'b1; ce_n = 1'b1;
      model[8'h2A] = 8'hE7;
      idle(SETTLE);
      check_loc(16'h002A, "R3 captured address");
      check_loc(16'h002B, "R3 untouched address");

      // R8: long session, loads spaced just inside the window, last write wins
      for (int i = 0; i < 12; i++) begin
         logic [15:0] a;
         a = 16'(5 * NBYTE + (i % NBYTE));
         load(a, 8'(i * 17 + 1), 4);
         model[a[AW_ARR-1:0]] = 8'(i * 17 + 1);
         check(busy == 1'b0, "R8 session open", 16'(busy), 16'd0);
         idle(15);
      end
      idle(SETTLE);
      for (int a = 40; a < 48; a++) check_loc(16'(a), "R8 long session");

      // R8/R9: a load after the window lands in the busy phase and is dropped
      load(16'h0038, 8'h11, 4); model[8'h38] = 8'h11;
      idle(38);
      check(busy == 1'b1, "R9 busy after window", 16'(busy), 16'd1);
      load(16'h0039, 8'h22, 4);
      idle(SETTLE);
      check_loc(16'h0038, "R8 first load");
      check_loc(16'h0039, "R9 late load ignored");

      // R9: busy lasts PROG cycles
      load(16'h003F, 8'h3F, 4); model[8'h3F] = 8'h3F;
      wait_rise(ok);
      check(ok, "R9 busy rises", 16'(ok), 16'd1);
      blen = 1;
      for (int k = 0; k < 2 * PROG; k++) begin
         @(negedge clk);
         if (!busy) break;
         blen++;
      end
      check(blen == PROG, "R9 busy length", 16'(blen), 16'(PROG));
      idle(5);

      // R10/R11: polling reads while programming
      load(16'h0033, 8'h5A, 4); model[8'h33] = 8'h5A;
      wait_rise(ok);
      for (int r = 0; r < 3; r++) begin
         bus_read(16'h0033, d, en);
         check(en == 1'b1, "R10 poll drives", 16'(en), 16'd1);
         check(d[7] == 1'b1, "R10 complement bit", 16'(d[7]), 16'd1);
         check(d[6] == 1'(r % 2), "R11 toggle bit", 16'(d[6]), 16'(r % 2));
         check(d[5:0] == 6'd0, "R11 low bits", 16'(d[5:0]), 16'd0);
      end
      idle(SETTLE);
      check_loc(16'h0033, "R11 true data after");
      load(16'h003C, 8'hC3, 4); model[8'h3C] = 8'hC3;
      wait_rise(ok);
      bus_read(16'h003C, d, en);
      check(d[7] == 1'b0, "R10 complement of one", 16'(d[7]), 16'd0);
      idle(SETTLE);

      // R4/R5: final sweep of the whole array
      for (int a = 0; a < NLOC; a++) check_loc(16'(a), "R4 final sweep");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule